// File: doc/BRIEF.md
# Barrel Shift and Bit-Field Unit

This unit is the shift lane of a 32-bit execute stage. On every cycle where the input strobe is high, it takes operand A and produces one of three results. The first is A shifted by any amount from 0 to 31. The second is a field pulled out of A. The third is A's low bits placed into a field of the previous destination value. The result is registered and appears one cycle later, together with an output strobe.

A shift takes its amount in one of two forms. In the register form, the amount comes from the low five bits of operand B and the type comes from a function field. In the immediate form, the amount and type both come from a 16-bit immediate field.

The immediate field can also select field extraction or field insertion. For these, it carries two 5-bit positions:
- a start bit;
- for extraction, a width; for insertion, the index of the field's last bit.

Insertion also reads the old destination value, so that every bit outside the field is preserved.

Top module: `bfs_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `result` is loaded one cycle after a cycle with `in_valid` high, and it holds its value while `in_valid` is low, even if the other inputs change.
- R3: A logical right shift by n moves A towards bit 0 and fills the top n bits with 0.
- R4: An arithmetic right shift by n fills the top n bits with copies of A[31].
- R5: A left shift by n moves A towards bit 31 and fills the low n bits with 0.
- R6: The register form is selected by `imm_form` = 0, which always performs a shift.
  - The amount is `opnd_b[4:0]`; bits 31:5 of B are ignored.
  - `func_field[10]` = 1 selects left. Otherwise `func_field[9]` = 1 selects arithmetic right. Otherwise the shift is logical right.
  - Field bits 8:0 are ignored.
- R7: The immediate form is selected by `imm_form` = 1 whenever `imm_field[15:11]` is neither 01000 nor 10000.
  - The unit then shifts by `imm_field[4:0]`.
  - `imm_field[10]` = 1 selects left. Otherwise `imm_field[9]` = 1 selects arithmetic right. Otherwise the shift is logical right.
- R8: A shift amount of 0 returns A unchanged, for every shift type.
- R9: Extraction is selected by `imm_form` = 1 and `imm_field[15:11]` = 01000.
  - The width is W = `imm_field[10:6]` and the start is S = `imm_field[4:0]`.
  - Bit i of the result, for i < W, is A[i+S] (0 when i+S > 31). All higher bits are 0.
- R10: An extraction with width W = 0 returns 0.
- R11: Insertion is selected by `imm_form` = 1 and `imm_field[15:11]` = 10000.
  - The last bit is E = `imm_field[10:6]` and the start is S = `imm_field[4:0]`.
  - Bit i lies inside the mask when exactly one of (i > E) and (i >= S) holds.
  - Inside the mask, bit i of the result is A[i-S]. Outside the mask, bit i keeps the old destination bit `dest_old[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| imm_form | input | 1 | 1 = immediate form, 0 = register form |
| func_field | input | 11 | Register-form function bits |
| imm_field | input | 16 | Immediate-form field: code, positions and amount |
| opnd_a | input | 32 | Source operand A |
| opnd_b | input | 32 | Operand B; bits 4:0 give the register-form amount |
| dest_old | input | 32 | Previous destination value, merged by insertion |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered result |

## Verification
Every shift type is run through all 32 amounts on two operands.
- One operand has a set sign bit and the other a clear one, so the zero fill and the sign fill produce visibly different top bits.
- Amount 0 is included, which shows whether the unit passes A through untouched.
- The upper bits of B are random, which shows whether only the low five bits set the amount.

A fixed table covers the two encoding forms and the priority when both type bits are set.

Random start/width pairs for extraction and insertion are compared against a bit-by-bit model. This exposes three kinds of error:
- a field cut off at bit 31;
- an empty extraction;
- an insertion that clobbers or keeps the wrong bits of the old destination. The old destination is all ones or a random pattern.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int FN_W      = 11;  // register-form function field width
  localparam int IMM_W     = 16;  // immediate field width
  localparam int CODE_W    = 5;   // field-operation code at the top of the immediate
  localparam int POS_W     = 5;   // start / width / end position width
  localparam int HI_POS    = 6;   // lsb of the width/end position in the immediate
  localparam int LEFT_BIT  = 10;  // selects left shift
  localparam int ARITH_BIT = 9;   // selects arithmetic right shift
  localparam logic [CODE_W-1:0] CODE_EXT = 5'b01000;
  localparam logic [CODE_W-1:0] CODE_INS = 5'b10000;

  typedef enum logic [1:0] {OP_SHIFT, OP_EXTRACT, OP_INSERT} op_kind_e;
  typedef enum logic [1:0] {SH_LOGIC, SH_ARITH, SH_LEFT} sh_kind_e;
endpackage

// File: rtl/bfs_decode.sv
module bfs_decode
  import bfs_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic             imm_form,
  input  logic [FN_W-1:0]  func_field,
  input  logic [IMM_W-1:0] imm_field,
  input  logic [AMT_W-1:0] b_amt,
  output op_kind_e         op_kind,
  output sh_kind_e         sh_kind,
  output logic [AMT_W-1:0] amount,
  output logic [AMT_W-1:0] fld_hi,
  output logic [AMT_W-1:0] fld_lo
);
  logic [CODE_W-1:0] code;
  logic left_bit, arith_bit;
  logic unused_dec;

  assign code       = imm_field[IMM_W-1 -: CODE_W];
  assign unused_dec = ^{func_field[ARITH_BIT-1:0], imm_field[HI_POS-1:AMT_W]};

  always_comb begin
    left_bit  = imm_form ? imm_field[LEFT_BIT]  : func_field[LEFT_BIT];
    arith_bit = imm_form ? imm_field[ARITH_BIT] : func_field[ARITH_BIT];
    amount    = imm_form ? imm_field[AMT_W-1:0] : b_amt;
    fld_lo    = imm_field[AMT_W-1:0];
    fld_hi    = imm_field[HI_POS +: AMT_W];
    if (imm_form && code == CODE_EXT)      op_kind = OP_EXTRACT;
    else if (imm_form && code == CODE_INS) op_kind = OP_INSERT;
    else                                   op_kind = OP_SHIFT;
    if (left_bit)       sh_kind = SH_LEFT;
    else if (arith_bit) sh_kind = SH_ARITH;
    else                sh_kind = SH_LOGIC;
  end
endmodule

// File: rtl/bfs_rshift.sv
module bfs_rshift #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              fill,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [AMT_W+1];
  assign stage[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  assign dout = stage[AMT_W];
endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  op_kind_e          op_kind,
  input  sh_kind_e          sh_kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic [AMT_W-1:0]  fld_hi,
  input  logic [AMT_W-1:0]  fld_lo,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] dest_old,
  output logic [DATA_W-1:0] result_c,
  output logic [DATA_W-1:0] ins_mask
);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) bit_rev[i] = v[DATA_W-1-i];
  endfunction

  // ones in the low w bits
  function automatic logic [DATA_W-1:0] low_mask(input logic [AMT_W-1:0] w);
    if (w == '0) return '0;
    return ONES >> (DATA_W - int'(w));
  endfunction

  // ones strictly above last XOR ones from start upward
  function automatic logic [DATA_W-1:0] span_mask(input logic [AMT_W-1:0] last,
                                                  input logic [AMT_W-1:0] start);
    logic [DATA_W:0]   above;
    logic [DATA_W-1:0] from_s;
    above  = {(DATA_W+1){1'b1}} << (int'(last) + 1);
    from_s = ONES << start;
    return above[DATA_W-1:0] ^ from_s;
  endfunction

  logic              go_left, fill;
  logic [AMT_W-1:0]  sh_amt;
  logic [DATA_W-1:0] sh_in, sh_out, shifted;

  assign go_left = (op_kind == OP_SHIFT && sh_kind == SH_LEFT) || op_kind == OP_INSERT;
  assign fill    = (op_kind == OP_SHIFT) && (sh_kind == SH_ARITH) && src_a[DATA_W-1];
  assign sh_amt  = (op_kind == OP_SHIFT) ? amount : fld_lo;
  assign sh_in   = go_left ? bit_rev(src_a) : src_a;

  bfs_rshift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_rshift (
    .din (sh_in),
    .amt (sh_amt),
    .fill(fill),
    .dout(sh_out)
  );

  assign shifted  = go_left ? bit_rev(sh_out) : sh_out;
  assign ins_mask = span_mask(fld_hi, fld_lo);

  always_comb begin
    case (op_kind)
      OP_EXTRACT: result_c = shifted & low_mask(fld_hi);
      OP_INSERT:  result_c = (shifted & ins_mask) | (dest_old & ~ins_mask);
      default:    result_c = shifted;
    endcase
  end
endmodule

// File: rtl/bfs_unit.sv
module bfs_unit
  import bfs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              imm_form,
  input  logic [FN_W-1:0]   func_field,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] dest_old,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int AMT_W = $clog2(DATA_W);

  op_kind_e          op_kind;
  sh_kind_e          sh_kind;
  logic [AMT_W-1:0]  amount, fld_hi, fld_lo;
  logic [DATA_W-1:0] result_c, ins_mask;
  logic              unused_b;

  assign unused_b = ^opnd_b[DATA_W-1:AMT_W];

  bfs_decode #(.AMT_W(AMT_W)) i_decode (
    .imm_form  (imm_form),
    .func_field(func_field),
    .imm_field (imm_field),
    .b_amt     (opnd_b[AMT_W-1:0]),
    .op_kind   (op_kind),
    .sh_kind   (sh_kind),
    .amount    (amount),
    .fld_hi    (fld_hi),
    .fld_lo    (fld_lo)
  );

  bfs_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_datapath (
    .op_kind (op_kind),
    .sh_kind (sh_kind),
    .amount  (amount),
    .fld_hi  (fld_hi),
    .fld_lo  (fld_lo),
    .src_a   (opnd_a),
    .dest_old(dest_old),
    .result_c(result_c),
    .ins_mask(ins_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= result_c;
    end
  end
endmodule

// File: rtl/bfs_unit_checker.sv
module bfs_unit_checker
  import bfs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] dest_old,
  input op_kind_e          op_kind,
  input sh_kind_e          sh_kind,
  input logic [AMT_W-1:0]  amount,
  input logic [AMT_W-1:0]  fld_hi,
  input logic [DATA_W-1:0] ins_mask,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  logic is_shift;
  assign is_shift = in_valid && op_kind == OP_SHIFT;

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_logic_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_shift && sh_kind == SH_LOGIC && amount != '0) |=> !result[DATA_W-1]);
  assert_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_shift && sh_kind == SH_ARITH) |=> result[DATA_W-1] == $past(opnd_a[DATA_W-1]));
  assert_left_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_shift && sh_kind == SH_LEFT && amount != '0) |=> !result[0]);
  assert_zero_amount_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_shift && amount == '0) |=> result == $past(opnd_a));
  assert_empty_extract_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == OP_EXTRACT && fld_hi == '0) |=> result == '0);
  assert_keep_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == OP_INSERT)
      |=> ((result ^ $past(dest_old)) & ~$past(ins_mask)) == '0);
endmodule

bind bfs_unit bfs_unit_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_bfs_unit_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opnd_a   (opnd_a),
  .dest_old (dest_old),
  .op_kind  (op_kind),
  .sh_kind  (sh_kind),
  .amount   (amount),
  .fld_hi   (fld_hi),
  .ins_mask (ins_mask),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/test_bfs_unit.sv
module test_bfs_unit;
  localparam int VEC_W = 1 + 11 + 16 + 32 * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        imm_form = 1'b0;
  logic [10:0] func_field = '0;
  logic [15:0] imm_field = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, dest_old = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bfs_unit i_bfs_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_form(imm_form),
    .func_field(func_field), .imm_field(imm_field), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .dest_old(dest_old), .out_valid(out_valid), .result(result)
  );

  // {form, func, imm, a, b, d, expected}
  localparam logic [VEC_W-1:0] VECS [12] = '{
    {1'b0, 11'h000, 16'h0000, 32'h8000_0000, 32'hFFFF_FFE4, 32'h0, 32'h0800_0000},
    {1'b0, 11'h200, 16'h0000, 32'h8000_0000, 32'h0000_0004, 32'h0, 32'hF800_0000},
    {1'b0, 11'h400, 16'h0000, 32'h0000_000F, 32'h0000_001C, 32'h0, 32'hF000_0000},
    {1'b0, 11'h600, 16'h0000, 32'h0000_0001, 32'h0000_0003, 32'h0, 32'h0000_0008},
    {1'b1, 11'h000, 16'h0008, 32'h1234_5678, 32'h0000_001F, 32'h0, 32'h0012_3456},
    {1'b1, 11'h000, 16'h0208, 32'h8765_4321, 32'h0, 32'h0, 32'hFF87_6543},
    {1'b1, 11'h000, 16'h0408, 32'h1234_5678, 32'h0, 32'h0, 32'h3456_7800},
    {1'b1, 11'h000, 16'h4204, 32'h1234_5678, 32'h0, 32'h0, 32'h0000_0067},
    {1'b1, 11'h000, 16'h4004, 32'h1234_5678, 32'h0, 32'h0, 32'h0000_0000},
    {1'b1, 11'h000, 16'h83C8, 32'h0000_00AB, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_ABFF},
    {1'b1, 11'h000, 16'h87C0, 32'hCAFE_F00D, 32'h0, 32'h1111_1111, 32'hCAFE_F00D},
    {1'b0, 11'h200, 16'h0000, 32'h8000_0001, 32'h0000_0020, 32'h0, 32'h8000_0001}
  };
  localparam string VEC_TAG [12] = '{"R6 R3", "R6 R4", "R6 R5", "R6", "R7 R3", "R7 R4",
                                     "R7 R5", "R9", "R10", "R11", "R11", "R8"};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic form, input logic [10:0] fn, input logic [15:0] imm,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; imm_form = form; func_field = fn; imm_field = imm;
    opnd_a = a; opnd_b = b; dest_old = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // bench models, bit by bit
  function automatic logic [31:0] m_shift(input int kind, input logic [31:0] a, input int n);
    for (int i = 0; i < 32; i++) begin
      if (kind == 2) m_shift[i] = (i - n >= 0) ? a[i-n] : 1'b0;
      else if (i + n < 32) m_shift[i] = a[i+n];
      else m_shift[i] = (kind == 1) ? a[31] : 1'b0;
    end
  endfunction

  function automatic logic [31:0] m_extract(input logic [31:0] a, input int w, input int s);
    for (int i = 0; i < 32; i++) m_extract[i] = (i < w && i + s < 32) ? a[i+s] : 1'b0;
  endfunction

  function automatic logic [31:0] m_insert(input logic [31:0] a, input logic [31:0] d,
                                           input int e, input int s);
    for (int i = 0; i < 32; i++) begin
      if ((i > e) != (i >= s)) m_insert[i] = (i >= s) ? a[i-s] : 1'b0;
      else m_insert[i] = d[i];
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'b0, out_valid}, 32'h0);
    chk("R1 result in reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'b0, out_valid}, 32'h0);
    chk("R1 result after reset", result, 32'h0);

    // table walk
    for (int v = 0; v < 12; v++) begin
      logic [VEC_W-1:0] t;
      t = VECS[v];
      run_op(t[155], t[154:144], t[143:128], t[127:96], t[95:64], t[63:32]);
      chk(VEC_TAG[v], result, t[31:0]);
    end

    // R2: strobe follows, result holds while idle
    run_op(1'b0, 11'h400, 16'h0, 32'h0000_0003, 32'h1, 32'h0);
    chk("R2 out_valid follows", {31'b0, out_valid}, 32'h1);
    held = result;
    opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h7;
    @(negedge clk);
    chk("R2 out_valid low", {31'b0, out_valid}, 32'h0);
    chk("R2 result held", result, held);
    chk("R5 held value", held, 32'h0000_0006);

    // every amount of every shift type, register form
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n < 32; n++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] a;
          logic [10:0] fn;
          string tag;
          a  = (p == 0) ? 32'h8F00_00F1 : 32'h5A5A_C3C3;
          fn = (k == 2) ? 11'h400 : (k == 1) ? 11'h200 : 11'h000;
          tag = (n == 0) ? "R8" : (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
          run_op(1'b0, fn, 16'h0, a, {27'($urandom), 5'(n)}, 32'h0);
          chk(tag, result, m_shift(k, a, n));
        end
      end
    end

    // random extractions
    for (int r = 0; r < 150; r++) begin
      logic [4:0] w, s;
      logic [31:0] a;
      w = 5'($urandom_range(31, 0));
      s = 5'($urandom_range(31, 0));
      a = $urandom;
      run_op(1'b1, 11'h0, {5'b01000, w, 1'b0, s}, a, 32'h0, 32'h0);
      chk((w == 0) ? "R10" : "R9", result, m_extract(a, int'(w), int'(s)));
    end

    // random insertions
    for (int r = 0; r < 150; r++) begin
      logic [4:0] e, s;
      logic [31:0] a, d;
      s = 5'($urandom_range(31, 0));
      e = 5'($urandom_range(31, 0));
      a = $urandom;
      d = (r % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
      run_op(1'b1, 11'h0, {5'b10000, e, 1'b0, s}, a, 32'h0, d);
      chk("R11", result, m_insert(a, d, int'(e), int'(s)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule